// File: doc/BRIEF.md
# SPI master with chip-select hold

A register-mapped serial peripheral master that shifts 8-bit characters, most significant bit first, with the serial clock idling low. Software first releases the block from its soft reset and turns on its enable, master and run bits. It then writes one combined command word that carries the data byte, a flag that keeps chip select asserted after the character, and the number of the chip-select line to use. That write starts the transfer. One further command can wait in a holding slot while a character is on the wire, so consecutive characters of a held burst follow each other with no idle clocks between them.

The serial clock period is a programmable number of module clocks. A phase bit picks whether data leads the first clock edge or the clock leads the data. Two programmable delays are counted in module clocks. One spaces the assertion of chip select from the first clock activity. The other spaces the final clock edge from the release of chip select. An idle-level register sets what each chip-select pin drives while it is not selected. A buffer register returns the received byte with a flag that shows no unread byte is present.

Top module: `spi_csm_top`

## Requirements
- R1: After reset the soft-reset bit (CTRL, address 0, bit 0) reads 1 and the idle levels (address 3) are all ones. Every cs_n line is high and sclk is low. In the status word (address 4 read, bit 0 = receive-empty, bit 1 = transmit-full) receive-empty reads 1 and transmit-full reads 0.
- R2: Transfers run only while CTRL bit 0 (soft reset) is 0 and bits 1 (enable), 2 (master) and 3 (run) are all 1. A command write made at any other time is dropped: no clock edges appear and transmit-full stays 0.
- R3: A write to address 4 (bits 7:0 data, bit 8 hold, bits 9 and up select) starts an 8-bit transfer. mosi carries the data MSB first, and the eight miso bits sampled MSB first become the received byte. That byte is read at address 5 in bits 7:0, with receive-empty in bit 8 and transmit-full in bit 9.
- R4: One bit lasts P module clocks, where P = prescale + 1 and prescale is address 1 bits 7:0. A prescale of 0 gives P = 2. Consecutive rising sclk edges inside a character are P clocks apart.
- R5: With CTRL bit 4 (phase) = 1, each bit is driven on mosi at the start of its slot with sclk low, and both sides sample on the rising edge, which comes ceil(P/2) clocks into the slot. With phase = 0, sclk rises at the start of each slot and both sides sample on the falling edge. sclk is low whenever no character is shifting.
- R6: When a transfer starts from idle, chip select asserts and the first bit slot begins exactly L module clocks later. L is address 2 bits 7:0.
- R7: When a character ends with hold clear, chip select releases exactly T module clocks after the end of the last bit slot. T is address 2 bits 15:8. With phase = 1 the end of the last slot is the last falling sclk edge.
- R8: When a character ends with hold set, chip select stays asserted. If a command is already waiting, its first slot starts on the next clock with no lead delay. Otherwise the block waits with chip select asserted and starts the next written command without a lead delay.
- R9: A burst of held characters closed by one with hold clear produces exactly one chip-select release, after the closing character.
- R10: Receive-empty goes to 0 when a character completes. A read of address 5 with reg_re high sets it back to 1. Reading address 4 has no side effect.
- R11: Transmit-full is 1 while a command waits in the holding slot. A command write made while transmit-full is 1 is dropped and never reaches the wire.
- R12: During a transfer, the line numbered by the select field is driven low. Every other cs_n line, and every line when no transfer is active, drives its bit of the idle-level register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe; enables read side effects |
| reg_addr | input | AW (3) | Register address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Register read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS (4) | Chip-select lines, active low |

## Verification
The hardest case to reach from the ports is the holding slot being occupied at the exact moment the shifting character finishes. A second case is a command arriving while the slot is still full. The stimulus sets a long lead delay and a short bit period. It polls transmit-full through the side-effect-free status address, so it can write the second command a clock after the first is taken and a third while the slot is known to be full. It then measures the largest interval between rising clock edges across the burst and counts chip-select releases to confirm the words ran back to back.

// File: rtl/spi_csm_pkg.sv
`timescale 1ns/1ps
package spi_csm_pkg;

    localparam int CHAR_W = 8;
    localparam int BIT_W  = $clog2(CHAR_W);
    localparam int PRE_W  = 8;
    localparam int DLY_W  = 8;
    localparam int PER_W  = PRE_W + 1;

    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_PRESC = 1;
    localparam int ADDR_DLY   = 2;
    localparam int ADDR_IDLE  = 3;
    localparam int ADDR_CMD   = 4;
    localparam int ADDR_RXBUF = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_HOLDW
    } eng_state_e;

    typedef struct packed {
        logic phase;
        logic go;
        logic master;
        logic en;
        logic soft_rst;
    } ctrl_t;

    typedef struct packed {
        logic              phase;
        logic [PRE_W-1:0]  presc;
        logic [DLY_W-1:0]  lead;
        logic [DLY_W-1:0]  trail;
    } xfer_cfg_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              hold;
    } word_cmd_t;

    function automatic logic [PER_W-1:0] bit_period(input logic [PRE_W-1:0] p);
        if (p == '0) return PER_W'(2);
        return PER_W'(p) + PER_W'(1);
    endfunction

endpackage

// File: rtl/spi_csm_regs.sv
`timescale 1ns/1ps
module spi_csm_regs
    import spi_csm_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2,
    parameter int AW  = 3,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              tx_full,
    output xfer_cfg_t         cfg,
    output logic              run_en,
    output logic [NCS-1:0]    idle_lvl,
    output logic              push_req,
    output word_cmd_t         push_cmd,
    output logic [CSW-1:0]    push_sel
);

    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  presc_q;
    logic [DLY_W-1:0]  lead_q;
    logic [DLY_W-1:0]  trail_q;
    logic [NCS-1:0]    idle_q;
    logic [CHAR_W-1:0] rx_data_q;
    logic              rx_empty_q;
    logic              rd_buf;

    function automatic logic hit(input logic [AW-1:0] a, input int k);
        return a == AW'(k);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{phase: 1'b0, go: 1'b0, master: 1'b0, en: 1'b0, soft_rst: 1'b1};
            presc_q <= '0;
            lead_q  <= '0;
            trail_q <= '0;
            idle_q  <= '1;
        end else if (reg_we) begin
            if (hit(reg_addr, ADDR_CTRL))  ctrl_q  <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
            if (hit(reg_addr, ADDR_PRESC)) presc_q <= reg_wdata[PRE_W-1:0];
            if (hit(reg_addr, ADDR_DLY)) begin
                lead_q  <= reg_wdata[DLY_W-1:0];
                trail_q <= reg_wdata[2*DLY_W-1:DLY_W];
            end
            if (hit(reg_addr, ADDR_IDLE))  idle_q  <= reg_wdata[NCS-1:0];
        end
    end

    assign rd_buf = reg_re && hit(reg_addr, ADDR_RXBUF);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_q  <= '0;
            rx_empty_q <= 1'b1;
        end else if (rx_valid) begin
            rx_data_q  <= rx_byte;
            rx_empty_q <= 1'b0;
        end else if (rd_buf) begin
            rx_empty_q <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(ADDR_CTRL):  reg_rdata = DW'(ctrl_q);
            AW'(ADDR_PRESC): reg_rdata = DW'(presc_q);
            AW'(ADDR_DLY):   reg_rdata = DW'({trail_q, lead_q});
            AW'(ADDR_IDLE):  reg_rdata = DW'(idle_q);
            AW'(ADDR_CMD):   reg_rdata = DW'({tx_full, rx_empty_q});
            AW'(ADDR_RXBUF): reg_rdata = DW'({tx_full, rx_empty_q, rx_data_q});
            default:         reg_rdata = '0;
        endcase
    end

    assign run_en   = !ctrl_q.soft_rst && ctrl_q.en && ctrl_q.master && ctrl_q.go;
    assign cfg      = '{phase: ctrl_q.phase, presc: presc_q, lead: lead_q, trail: trail_q};
    assign idle_lvl = idle_q;
    assign push_req = reg_we && hit(reg_addr, ADDR_CMD);
    assign push_cmd = '{data: reg_wdata[CHAR_W-1:0], hold: reg_wdata[CHAR_W]};
    assign push_sel = reg_wdata[CHAR_W+1 +: CSW];

    // R10
    rx_arrival_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_empty_q);

    // R10
    rx_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_buf && !rx_valid) |=> rx_empty_q);

endmodule

// File: rtl/spi_csm_engine.sv
`timescale 1ns/1ps
module spi_csm_engine
    import spi_csm_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CSW = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  xfer_cfg_t         cfg,
    input  logic              push_req,
    input  word_cmd_t         push_cmd,
    input  logic [CSW-1:0]    push_sel,
    input  logic              miso,
    output logic              tx_full,
    output logic              rx_valid,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_act,
    output logic [CSW-1:0]    cs_sel
);

    eng_state_e        state;
    logic              hold_valid;
    word_cmd_t         hold_cmd;
    logic [CSW-1:0]    hold_sel;
    logic [PER_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [DLY_W-1:0]  dly_cnt;
    logic [CHAR_W-1:0] tx_sr;
    logic [CHAR_W-1:0] rx_sr;
    logic              cur_hold;

    logic [PER_W-1:0]  per;
    logic [PER_W-1:0]  first_len;
    logic              accept;
    logic              bit_end;
    logic              word_done;
    logic              take;

    assign per       = bit_period(cfg.presc);
    assign first_len = per - (per >> 1);
    assign accept    = push_req && run_en && !hold_valid;
    assign bit_end   = (state == ST_SHIFT) && (cnt == per - PER_W'(1));
    assign word_done = bit_end && (bit_idx == BIT_W'(CHAR_W - 1));

    always_comb begin
        take = 1'b0;
        if (run_en && hold_valid) begin
            unique case (state)
                ST_IDLE, ST_HOLDW: take = 1'b1;
                ST_SHIFT:          take = word_done && cur_hold;
                default:           take = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            hold_valid <= 1'b0;
        end else if (accept) begin
            hold_valid <= 1'b1;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cmd <= '0;
            hold_sel <= '0;
        end else if (accept) begin
            hold_cmd <= push_cmd;
            hold_sel <= push_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            dly_cnt  <= '0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            cur_hold <= 1'b0;
            cs_sel   <= '0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!run_en) begin
                state <= ST_IDLE;
            end else begin
                if (take) begin
                    tx_sr    <= hold_cmd.data;
                    cur_hold <= hold_cmd.hold;
                    cs_sel   <= hold_sel;
                    cnt      <= '0;
                    bit_idx  <= '0;
                end
                unique case (state)
                    ST_IDLE: begin
                        if (hold_valid) begin
                            if (cfg.lead == '0) begin
                                state <= ST_SHIFT;
                            end else begin
                                state   <= ST_LEAD;
                                dly_cnt <= cfg.lead;
                            end
                        end
                    end
                    ST_LEAD: begin
                        if (dly_cnt <= DLY_W'(1)) state <= ST_SHIFT;
                        else                      dly_cnt <= dly_cnt - DLY_W'(1);
                    end
                    ST_SHIFT: begin
                        if (cnt == first_len - PER_W'(1)) begin
                            rx_sr <= {rx_sr[CHAR_W-2:0], miso};
                        end
                        if (word_done) begin
                            rx_valid <= 1'b1;
                            rx_byte  <= rx_sr;
                            if (cur_hold) begin
                                if (!hold_valid) state <= ST_HOLDW;
                            end else if (cfg.trail == '0) begin
                                state <= ST_IDLE;
                            end else begin
                                state   <= ST_TRAIL;
                                dly_cnt <= cfg.trail;
                            end
                        end else if (bit_end) begin
                            tx_sr   <= {tx_sr[CHAR_W-2:0], 1'b0};
                            bit_idx <= bit_idx + BIT_W'(1);
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + PER_W'(1);
                        end
                    end
                    ST_TRAIL: begin
                        if (dly_cnt <= DLY_W'(1)) state <= ST_IDLE;
                        else                      dly_cnt <= dly_cnt - DLY_W'(1);
                    end
                    ST_HOLDW: begin
                        if (hold_valid) state <= ST_SHIFT;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_full = hold_valid;
    assign cs_act  = (state != ST_IDLE);
    assign mosi    = (state == ST_SHIFT) ? tx_sr[CHAR_W-1] : 1'b0;
    assign sclk    = (state == ST_SHIFT) &&
                     (cfg.phase ? (cnt >= first_len) : (cnt < first_len));

    // R8
    hold_keeps_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (word_done && cur_hold && run_en) |=> cs_act);

    // R6
    lead_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hold_valid && run_en && cfg.lead != '0) |=> (state == ST_LEAD));

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && tx_full) |=> $stable(hold_cmd));

    // R2
    disabled_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (!cs_act && !tx_full));

endmodule

// File: rtl/spi_csm_top.sv
`timescale 1ns/1ps
module spi_csm_top
    import spi_csm_pkg::*;
#(
    parameter int NCS = 4,
    parameter int AW  = 3,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic           reg_re,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NCS-1:0] cs_n
);

    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;

    xfer_cfg_t         cfg;
    logic              run_en;
    logic [NCS-1:0]    idle_lvl;
    logic              push_req;
    word_cmd_t         push_cmd;
    logic [CSW-1:0]    push_sel;
    logic              tx_full;
    logic              rx_valid;
    logic [CHAR_W-1:0] rx_byte;
    logic              cs_act;
    logic [CSW-1:0]    cs_sel;

    spi_csm_regs #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_full   (tx_full),
        .cfg       (cfg),
        .run_en    (run_en),
        .idle_lvl  (idle_lvl),
        .push_req  (push_req),
        .push_cmd  (push_cmd),
        .push_sel  (push_sel)
    );

    spi_csm_engine #(.NCS(NCS), .CSW(CSW)) engine_i (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .cfg       (cfg),
        .push_req  (push_req),
        .push_cmd  (push_cmd),
        .push_sel  (push_sel),
        .miso      (miso),
        .tx_full   (tx_full),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .sclk      (sclk),
        .mosi      (mosi),
        .cs_act    (cs_act),
        .cs_sel    (cs_sel)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = (cs_act && cs_sel == CSW'(i)) ? 1'b0 : idle_lvl[i];
    end

    // R12
    cs_single_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n & idle_lvl) <= 1);

endmodule

// File: tb/spi_csm_top_tb_top.sv
`timescale 1ns/1ps
module spi_csm_top_tb_top;

    localparam int NCS = 4;
    localparam int AW  = 3;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_we = 1'b0;
    logic           reg_re = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [DW-1:0]  reg_wdata = '0;
    logic [DW-1:0]  reg_rdata;
    logic           sclk;
    logic           mosi;
    logic           miso;
    logic [NCS-1:0] cs_n;

    always #2 clk = ~clk;

    spi_csm_top #(.NCS(NCS), .AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // slave model and scoreboard
    logic       tb_phase = 1'b1;
    logic [7:0] slv_cur = 8'h00;
    logic [7:0] slv_cap = 8'h00;
    int         slv_bits = 0;
    bit         slv_loaded = 0;
    logic       miso_r = 1'b0;
    logic [7:0] miso_q[$];
    logic [7:0] exp_q[$];
    assign miso = miso_r;

    always @(sclk) begin
        if (sclk === tb_phase) begin
            slv_cap = {slv_cap[6:0], mosi};
            slv_bits++;
            if (slv_bits == 8) begin
                slv_bits = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R11 unexpected word on mosi", slv_cap, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(slv_cap == e, "R3/R5 mosi byte", slv_cap, e);
                end
                if (miso_q.size() != 0) slv_cur = miso_q.pop_front();
                else begin slv_cur = 8'h00; slv_loaded = 0; end
            end
            #1 miso_r = slv_cur[7 - slv_bits];
        end
    end

    time last_rise = 0, last_fall = 0, max_gap = 0;
    int  rise_cnt = 0, cs0_rise_cnt = 0;
    bit  track = 0;

    always @(posedge sclk) begin
        rise_cnt++;
        if (track && last_rise != 0 && ($time - last_rise) > max_gap) max_gap = $time - last_rise;
        last_rise = $time;
    end
    always @(negedge sclk) last_fall = $time;
    always @(posedge cs_n[0]) cs0_rise_cnt++;

    task automatic wr_reg(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_status(output logic [DW-1:0] v);
        @(negedge clk);
        reg_re = 1'b0; reg_addr = AW'(4);
        #1 v = reg_rdata;
    endtask

    task automatic wait_txfree();
        logic [DW-1:0] v;
        do rd_status(v); while (v[1] == 1'b1);
    endtask

    task automatic drive_word(input logic [7:0] d, input bit hold, input int sel, input logic [7:0] m);
        wait_txfree();
        exp_q.push_back(d);
        if (!slv_loaded) begin slv_cur = m; slv_loaded = 1; miso_r = m[7]; end
        else miso_q.push_back(m);
        wr_reg(4, DW'({2'(sel), hold, d}));
    endtask

    task automatic read_rx(input string req, input logic [7:0] exp);
        logic [DW-1:0] v;
        int guard = 0;
        do begin rd_status(v); guard++; end while (v[0] == 1'b1 && guard < 3000);
        check(v[0] == 1'b0, "R10 receive-empty cleared by arrival", v[0], 0);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = AW'(5);
        #1 v = reg_rdata;
        check(v[7:0] == exp, req, v[7:0], exp);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        time t0, t1, t2, tw;
        int  r0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(cs_n == 4'hF, "R1 cs_n after reset", cs_n, 15);
        check(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        rd_status(v);
        check(v[1:0] == 2'b01, "R1 status after reset", v[1:0], 1);
        reg_addr = AW'(0); #1;
        check(reg_rdata[0] == 1'b1, "R1 soft reset bit", reg_rdata[0], 1);

        // R2 write while held in soft reset
        r0 = rise_cnt;
        wr_reg(4, 32'h0AB);
        repeat (40) @(negedge clk);
        rd_status(v);
        check(v[1] == 1'b0, "R2 tx_full while disabled", v[1], 0);
        check(rise_cnt == r0 && cs_n == 4'hF, "R2 no activity while disabled", rise_cnt - r0, 0);

        // phase 1, P=4, lead 2, trail 3
        wr_reg(1, 3);
        wr_reg(2, 32'h0302);
        wr_reg(0, 32'h1E);
        tb_phase = 1'b1;
        fork
            drive_word(8'hA5, 0, 0, 8'h3C);
            begin
                @(negedge cs_n[0]); t0 = $time;
                @(posedge sclk);    t1 = $time;
                @(posedge sclk);    t2 = $time;
            end
        join
        check((t1 - t0) == 16, "R6/R5 phase1 lead plus half slot", t1 - t0, 16);
        check((t2 - t1) == 16, "R4 bit period P=4", t2 - t1, 16);
        @(posedge cs_n[0]);
        check(($time - last_fall) == 12, "R7 clock to cs release", $time - last_fall, 12);
        read_rx("R3 received byte phase1", 8'h3C);
        rd_status(v);
        check(v[0] == 1'b1, "R10 receive-empty set by read", v[0], 1);

        // phase 0, P=2 (prescale 0), lead 5, trail 0
        wr_reg(1, 0);
        wr_reg(2, 32'h0005);
        wr_reg(0, 32'h0E);
        tb_phase = 1'b0;
        fork
            drive_word(8'h5A, 0, 0, 8'hC3);
            begin
                @(negedge cs_n[0]); t0 = $time;
                @(posedge sclk);    t1 = $time;
                @(posedge sclk);    t2 = $time;
            end
        join
        check((t1 - t0) == 20, "R6/R5 phase0 lead delay", t1 - t0, 20);
        check((t2 - t1) == 8, "R4 bit period prescale 0", t2 - t1, 8);
        read_rx("R3 received byte phase0", 8'hC3);

        // held burst with preload and a dropped write
        wr_reg(1, 1);
        wr_reg(2, 32'h020A);
        wr_reg(0, 32'h1E);
        tb_phase = 1'b1;
        r0 = rise_cnt;
        cs0_rise_cnt = 0;
        last_rise = 0; max_gap = 0; track = 1;
        drive_word(8'h11, 1, 0, 8'h01);
        drive_word(8'h22, 1, 0, 8'h02);
        rd_status(v);
        check(v[1] == 1'b1, "R11 transmit-full with preload", v[1], 1);
        wr_reg(4, 32'h099);
        drive_word(8'h33, 0, 0, 8'h03);
        @(posedge cs_n[0]);
        repeat (20) @(negedge clk);
        track = 0;
        check(rise_cnt - r0 == 24, "R11 dropped write adds no clocks", rise_cnt - r0, 24);
        check(cs0_rise_cnt == 1, "R9 single release for burst", cs0_rise_cnt, 1);
        check(max_gap == 8, "R8 no lead gap between held words", max_gap, 8);
        read_rx("R3 last byte of burst", 8'h03);

        // hold with an idle pause
        drive_word(8'h44, 1, 0, 8'h04);
        read_rx("R3 held word byte", 8'h04);
        repeat (100) @(negedge clk);
        check(cs_n[0] == 1'b0, "R8 cs stays asserted after held word", cs_n[0], 0);
        wait_txfree();
        exp_q.push_back(8'h55);
        slv_cur = 8'h05; slv_loaded = 1; miso_r = 1'b0;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(4); reg_wdata = 32'h055;
        @(posedge clk); tw = $time;
        @(negedge clk); reg_we = 1'b0;
        @(posedge sclk); t1 = $time;
        check((t1 - tw) == 8, "R8 resumed word starts without lead", t1 - tw, 8);
        repeat (60) @(negedge clk);
        check(cs_n[0] == 1'b1, "R9 cs released after closing word", cs_n[0], 1);
        read_rx("R3 resumed word byte", 8'h05);

        // chip-select number and idle levels
        fork
            drive_word(8'h66, 0, 2, 8'h06);
            begin
                @(posedge sclk); #1;
                check(cs_n == 4'b1011, "R12 select line 2", cs_n, 11);
            end
        join
        read_rx("R3 byte on line 2", 8'h06);
        repeat (20) @(negedge clk);
        wr_reg(3, 32'h6);
        @(negedge clk);
        check(cs_n == 4'b0110, "R12 idle levels driven", cs_n, 6);
        fork
            drive_word(8'h77, 0, 1, 8'h07);
            begin
                @(posedge sclk); #1;
                check(cs_n == 4'b0100, "R12 select line 1 over idle levels", cs_n, 4);
            end
        join
        read_rx("R3 byte on line 1", 8'h07);
        repeat (20) @(negedge clk);

        // R2 run bit cleared
        wr_reg(0, 32'h16);
        r0 = rise_cnt;
        wr_reg(4, 32'h0AB);
        repeat (40) @(negedge clk);
        rd_status(v);
        check(v[1] == 1'b0 && rise_cnt == r0, "R2 write dropped with run bit clear", rise_cnt - r0, 0);

        check(exp_q.size() == 0, "R11 all queued words seen", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule